// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small field-configurable logic device built from ordinary synchronous logic. Four dedicated inputs and four macrocell feedback signals, each offered in true and inverted form, feed a programmable AND plane of product terms. The OR plane is fixed. Every output owns four product terms and sums only those. Each output then passes through a macrocell. The macrocell picks combinational bypass or a storage element, picks the output polarity, and picks the storage type: D, JK, set/reset or toggle flip-flop, or a transparent latch. Each pin can act as an input, an output, or a bidirectional pin whose drive enable comes from a product term.

The configuration is a single 284-bit word. It is shifted in serially while a load enable is high, and the word being loaded sits in a holding register. It takes effect only when a commit strobe is pulsed. All pin drivers are released while loading is under way. Pin drive is presented as a data output plus an output-enable per pin, and the pad value comes back on a separate input.

Top module: `pal_array`

## Requirements
- R1: A product term is the AND of the literals whose fuse bit is set. Within a term's 16 fuse bits, bit 2s selects signal s true and bit 2s+1 selects signal s inverted. Signals 0..3 are in_i[0..3] and signals 4..7 are the feedback values of outputs 0..3. A term with no fuse set is 1, and a term that selects both forms of one signal is 0.
- R2: Output m sums only its own terms 0..3. The full sum is the OR of all four. Sum A is term0|term1 and sum B is term2|term3, except that term3 is left out of every sum in bidirectional mode.
- R3: With the combinational bit set, the output value is the full sum. The storage element still updates each clock by its type.
- R4: With the polarity bit set, pin_o is the inverse of the macrocell value.
- R5: Storage type code 0 (and codes 5..7) loads the full sum each clock. Code 3 toggles the state when the full sum is 1.
- R6: Code 1 is a JK flip-flop with J = sum A and K = sum B: 00 holds, 10 sets, 01 clears, 11 toggles.
- R7: Code 2 is a set/reset flip-flop with S = sum A and R = sum B. When both are 1, the state holds.
- R8: Code 4 is a transparent latch with data = sum A and gate = sum B. While the gate is 1, the output follows the data with no clock. While the gate is 0, it shows the stored value, and the clock captures the data only while the gate is 1.
- R9: A registered output whose pin drives (direction 1 or 2) feeds back its stored state. Otherwise the feedback is pin_i of that output.
- R10: Direction code 1 always drives and code 2 drives when term3 is 1. Codes 0 and 3 never drive.
- R11: Each clock with cfg_load high shifts cfg_si into bit 0 of a holding word, and bits move towards the MSB, so the first bit sent ends at bit 283. A cfg_commit copies the holding word into the active configuration at that edge. Until then, outputs follow the previous configuration. Output m uses bits [m*71 +: 71]: fuses of term t at [t*16 +: 16], then bit 64 combinational, bit 65 polarity, bits 66..68 storage type, and bits 69..70 direction.
- R12: pin_oe is all zero in every cycle in which cfg_load is high.
- R13: Synchronous active-high reset clears the state, the holding word and the active configuration, so after reset pin_o and pin_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Shift enable for the configuration word |
| cfg_si | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copies the holding word into the active configuration |
| in_i | input | 4 | Dedicated array inputs |
| pin_i | input | 4 | Pad values seen at the output pins |
| pin_o | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin drive enables |

## Verification
The assertions assume that reset is applied before any configuration is used, and that the storage-type and direction fields hold the defined codes, with undefined codes falling back to D and to input. They also take the inputs and pad values as free from any combinational dependence on pin_o. For that reason the stimulus drives pin_i independently of the outputs and never closes a loop through the pads. Random configurations draw only defined type and direction codes. Fuse density is kept low so that product terms are not almost always 0, and both the shift and commit controls are only ever changed away from the clock edge.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned DEF_NUM_IN    = 4;
    localparam int unsigned DEF_NUM_MC    = 4;
    localparam int unsigned DEF_PT_PER_MC = 4;

    typedef enum logic [2:0] {
        ST_D     = 3'd0,
        ST_JK    = 3'd1,
        ST_RS    = 3'd2,
        ST_T     = 3'd3,
        ST_LATCH = 3'd4
    } store_kind_e;

    typedef enum logic [1:0] {
        PIN_IN    = 2'd0,
        PIN_OUT   = 2'd1,
        PIN_BIDIR = 2'd2
    } pin_dir_e;

    // Per-macrocell control field, sits above the fuse bits of its slice.
    typedef struct packed {
        logic [1:0] dir;
        logic [2:0] kind;
        logic       pol;
        logic       comb;
    } mc_ctrl_t;

    localparam int unsigned CTRL_BITS = $bits(mc_ctrl_t);

    // Next value of a storage element for the chosen type.
    function automatic logic store_next(input logic [2:0] kind, input logic q,
                                        input logic a, input logic b,
                                        input logic all);
        logic nxt;
        if (kind == ST_JK)
            nxt = (a & ~q) | (~b & q);
        else if (kind == ST_RS)
            nxt = (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
        else if (kind == ST_T)
            nxt = q ^ all;
        else if (kind == ST_LATCH)
            nxt = b ? a : q;
        else
            nxt = all;
        return nxt;
    endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int unsigned CFG_W = 284
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             si,
    input  logic             commit,
    output logic [CFG_W-1:0] active
);

    logic [CFG_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            active <= '0;
        end else begin
            if (shift_en)
                hold_q <= {hold_q[CFG_W-2:0], si};
            if (commit)
                active <= hold_q;
        end
    end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int unsigned N_SIG  = 8,
    parameter int unsigned N_TERM = 4
) (
    input  logic [N_SIG-1:0]          sig,
    input  logic [N_TERM*2*N_SIG-1:0] fuse,
    output logic [N_TERM-1:0]         term
);

    localparam int unsigned LIT_W = 2 * N_SIG;

    logic [LIT_W-1:0] lit;

    always_comb begin
        for (int s = 0; s < N_SIG; s++) begin
            lit[2*s]   = sig[s];
            lit[2*s+1] = ~sig[s];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // An unselected literal is forced to 1 so an empty term is true.
        assign term[t] = &(lit | ~fuse[t*LIT_W +: LIT_W]);
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int unsigned PT_PER_MC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mc_ctrl_t             ctrl,
    input  logic [PT_PER_MC-1:0] term,
    input  logic                 pin_i,
    input  logic                 loading,
    output logic                 pin_o,
    output logic                 pin_oe,
    output logic                 fb,
    output logic                 q,
    output logic                 sum_a,
    output logic                 sum_b,
    output logic                 sum_all
);

    localparam int unsigned HALF = PT_PER_MC / 2;
    localparam int unsigned OE_T = PT_PER_MC - 1;

    logic                 bidir;
    logic                 drives;
    logic [PT_PER_MC-1:0] use_mask;
    logic                 val;

    always_comb begin
        bidir  = (ctrl.dir == PIN_BIDIR);
        drives = (ctrl.dir == PIN_OUT) || bidir;
        use_mask = '1;
        if (bidir)
            use_mask[OE_T] = 1'b0;
    end

    assign sum_all = |(term & use_mask);
    assign sum_a   = |term[HALF-1:0];
    assign sum_b   = |(term[PT_PER_MC-1:HALF] & use_mask[PT_PER_MC-1:HALF]);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= store_next(ctrl.kind, q, sum_a, sum_b, sum_all);
    end

    always_comb begin
        if (ctrl.comb)
            val = sum_all;
        else if (ctrl.kind == ST_LATCH)
            val = sum_b ? sum_a : q;
        else
            val = q;
    end

    assign pin_o = val ^ ctrl.pol;

    always_comb begin
        if (loading)
            pin_oe = 1'b0;
        else if (ctrl.dir == PIN_OUT)
            pin_oe = 1'b1;
        else if (bidir)
            pin_oe = term[OE_T];
        else
            pin_oe = 1'b0;
    end

    assign fb = (!ctrl.comb && drives) ? q : pin_i;

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int unsigned NUM_IN    = DEF_NUM_IN,
    parameter int unsigned NUM_MC    = DEF_NUM_MC,
    parameter int unsigned PT_PER_MC = DEF_PT_PER_MC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              cfg_si,
    input  logic              cfg_commit,
    input  logic [NUM_IN-1:0] in_i,
    input  logic [NUM_MC-1:0] pin_i,
    output logic [NUM_MC-1:0] pin_o,
    output logic [NUM_MC-1:0] pin_oe
);

    localparam int unsigned N_SIG   = NUM_IN + NUM_MC;
    localparam int unsigned PT_BITS = 2 * N_SIG;
    localparam int unsigned MC_FUSE = PT_PER_MC * PT_BITS;
    localparam int unsigned MC_BITS = MC_FUSE + CTRL_BITS;
    localparam int unsigned CFG_W   = NUM_MC * MC_BITS;

    logic [CFG_W-1:0]             cfg_active;
    logic [N_SIG-1:0]             sig;
    logic [NUM_MC-1:0]            fb_vec;
    logic [NUM_MC-1:0]            q_vec;
    logic [NUM_MC-1:0]            sa_vec;
    logic [NUM_MC-1:0]            sb_vec;
    logic [NUM_MC-1:0]            sall_vec;
    mc_ctrl_t [NUM_MC-1:0]        mc_ctrl;

    pal_cfg_chain #(.CFG_W(CFG_W)) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_load),
        .si       (cfg_si),
        .commit   (cfg_commit),
        .active   (cfg_active)
    );

    assign sig = {fb_vec, in_i};

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        logic [PT_PER_MC-1:0] term;
        logic [MC_FUSE-1:0]   fuse;

        assign fuse       = cfg_active[m*MC_BITS +: MC_FUSE];
        assign mc_ctrl[m] = mc_ctrl_t'(cfg_active[m*MC_BITS + MC_FUSE +: CTRL_BITS]);

        pal_and_plane #(.N_SIG(N_SIG), .N_TERM(PT_PER_MC)) i_plane (
            .sig  (sig),
            .fuse (fuse),
            .term (term)
        );

        pal_macrocell #(.PT_PER_MC(PT_PER_MC)) i_cell (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (mc_ctrl[m]),
            .term    (term),
            .pin_i   (pin_i[m]),
            .loading (cfg_load),
            .pin_o   (pin_o[m]),
            .pin_oe  (pin_oe[m]),
            .fb      (fb_vec[m]),
            .q       (q_vec[m]),
            .sum_a   (sa_vec[m]),
            .sum_b   (sb_vec[m]),
            .sum_all (sall_vec[m])
        );
    end

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk
    import pal_pkg::*;
#(
    parameter int unsigned NUM_MC = DEF_NUM_MC
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_load,
    input logic [NUM_MC-1:0]     pin_oe,
    input mc_ctrl_t [NUM_MC-1:0] mc_ctrl,
    input logic [NUM_MC-1:0]     q_vec,
    input logic [NUM_MC-1:0]     sa_vec,
    input logic [NUM_MC-1:0]     sb_vec,
    input logic [NUM_MC-1:0]     sall_vec
);

    assert_reset_clear_R13: assert property (@(posedge clk)
        rst |=> (q_vec == '0));

    for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
        assert_no_drive_loading_R12: assert property (@(posedge clk) disable iff (rst)
            cfg_load |-> !pin_oe[m]);

        assert_input_undriven_R10: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].dir == PIN_IN) |-> !pin_oe[m]);

        assert_d_capture_R5: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].kind == ST_D) |=> (q_vec[m] == $past(sall_vec[m])));

        assert_t_toggle_R5: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].kind == ST_T && sall_vec[m]) |=> (q_vec[m] != $past(q_vec[m])));

        assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].kind == ST_JK && sa_vec[m] && sb_vec[m]) |=> (q_vec[m] != $past(q_vec[m])));

        assert_rs_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].kind == ST_RS && sa_vec[m] && sb_vec[m]) |=> $stable(q_vec[m]));

        assert_latch_closed_R8: assert property (@(posedge clk) disable iff (rst)
            (mc_ctrl[m].kind == ST_LATCH && !sb_vec[m]) |=> $stable(q_vec[m]));
    end

endmodule

bind pal_array pal_array_chk #(.NUM_MC(NUM_MC)) i_pal_array_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .pin_oe   (pin_oe),
    .mc_ctrl  (mc_ctrl),
    .q_vec    (q_vec),
    .sa_vec   (sa_vec),
    .sb_vec   (sb_vec),
    .sall_vec (sall_vec)
);

// File: tb/test_pal_array.sv
module test_pal_array;

    localparam int CLK_PERIOD = 10;
    localparam int NM  = 4;
    localparam int PTB = 16;
    localparam int MCB = 71;
    localparam int CW  = NM * MCB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic          cfg_si = 1'b0;
    logic          cfg_commit = 1'b0;
    logic [3:0]    in_r = 4'h0;
    logic [3:0]    pin_r = 4'h0;
    logic [3:0]    pin_o;
    logic [3:0]    pin_oe;

    int n_checks = 0;
    int n_errors = 0;

    logic [CW-1:0] m_active = '0;
    logic [CW-1:0] m_shadow = '0;
    logic [3:0]    m_q = 4'h0;

    logic [15:0]   fz [NM][4];
    logic [6:0]    ctl [NM];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_array i_pal_array (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_si     (cfg_si),
        .cfg_commit (cfg_commit),
        .in_i       (in_r),
        .pin_i      (pin_r),
        .pin_o      (pin_o),
        .pin_oe     (pin_oe)
    );

    function automatic logic term_val(input logic [CW-1:0] cfg, input int m,
                                      input int t, input logic [7:0] sg);
        logic [15:0] f;
        logic r;
        f = cfg[m*MCB + t*PTB +: PTB];
        r = 1'b1;
        for (int s = 0; s < 8; s++) begin
            if (f[2*s] && !sg[s])   r = 1'b0;
            if (f[2*s+1] && sg[s])  r = 1'b0;
        end
        return r;
    endfunction

    function automatic void model_eval(input logic [CW-1:0] cfg, input logic [3:0] q,
                                       input logic [3:0] iv, input logic [3:0] pv,
                                       input logic ld, output logic [3:0] o,
                                       output logic [3:0] oe, output logic [3:0] nq);
        logic [3:0] fbv;
        logic [7:0] sg;
        logic [6:0] c;
        logic t0, t1, t2, t3, bd, sall, sa, sb, v;
        for (int m = 0; m < NM; m++) begin
            c = cfg[m*MCB + 64 +: 7];
            fbv[m] = (!c[0] && (c[6:5] == 2'd1 || c[6:5] == 2'd2)) ? q[m] : pv[m];
        end
        sg = {fbv, iv};
        for (int m = 0; m < NM; m++) begin
            c  = cfg[m*MCB + 64 +: 7];
            t0 = term_val(cfg, m, 0, sg);
            t1 = term_val(cfg, m, 1, sg);
            t2 = term_val(cfg, m, 2, sg);
            t3 = term_val(cfg, m, 3, sg);
            bd = (c[6:5] == 2'd2);
            sall = t0 | t1 | t2 | (t3 & !bd);
            sa = t0 | t1;
            sb = t2 | (t3 & !bd);
            case (c[4:2])
                3'd1: nq[m] = sa ? (sb ? !q[m] : 1'b1) : (sb ? 1'b0 : q[m]);
                3'd2: nq[m] = (sa && !sb) ? 1'b1 : ((sb && !sa) ? 1'b0 : q[m]);
                3'd3: nq[m] = sall ? !q[m] : q[m];
                3'd4: nq[m] = sb ? sa : q[m];
                default: nq[m] = sall;
            endcase
            if (c[0])                v = sall;
            else if (c[4:2] == 3'd4) v = sb ? sa : q[m];
            else                     v = q[m];
            o[m] = c[1] ? !v : v;
            if (ld)                   oe[m] = 1'b0;
            else if (c[6:5] == 2'd1)  oe[m] = 1'b1;
            else if (bd)              oe[m] = t3;
            else                      oe[m] = 1'b0;
        end
    endfunction

    task automatic check_val(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        logic [3:0] eo, eoe, nq;
        model_eval(m_active, m_q, in_r, pin_r, cfg_load, eo, eoe, nq);
        check_val({req, " pin_o"}, pin_o, eo);
        check_val({req, " pin_oe"}, pin_oe, eoe);
    endtask

    task automatic step(input logic si, input logic sh, input logic upd);
        logic [3:0] eo, eoe, nq;
        cfg_si = si;
        cfg_load = sh;
        cfg_commit = upd;
        #1;
        model_eval(m_active, m_q, in_r, pin_r, sh, eo, eoe, nq);
        @(posedge clk);
        m_q = nq;
        if (upd) m_active = m_shadow;
        if (sh)  m_shadow = {m_shadow[CW-2:0], si};
        @(negedge clk);
        cfg_si = 1'b0;
        cfg_load = 1'b0;
        cfg_commit = 1'b0;
    endtask

    function automatic logic [CW-1:0] pack_cfg();
        logic [CW-1:0] v;
        v = '0;
        for (int m = 0; m < NM; m++) begin
            for (int t = 0; t < 4; t++) v[m*MCB + t*PTB +: PTB] = fz[m][t];
            v[m*MCB + 64 +: 7] = ctl[m];
        end
        return v;
    endfunction

    task automatic blank_cfg();
        for (int m = 0; m < NM; m++) begin
            for (int t = 0; t < 4; t++) fz[m][t] = 16'h0003;
            ctl[m] = 7'h00;
        end
    endtask

    task automatic shift_cfg();
        logic [CW-1:0] v;
        v = pack_cfg();
        for (int i = CW - 1; i >= 0; i--) begin
            if (i % 64 == 0) begin
                cfg_load = 1'b1;
                #1;
                check_val("R12 drivers released while loading", pin_oe, 4'h0);
            end
            step(v[i], 1'b1, 1'b0);
        end
    endtask

    task automatic load_cfg();
        shift_cfg();
        step(1'b0, 1'b0, 1'b1);
    endtask

    // ctl fields: {dir[1:0], kind[2:0], pol, comb}
    function automatic logic [6:0] mk_ctl(input logic [1:0] d, input logic [2:0] k,
                                          input logic p, input logic cb);
        return {d, k, p, cb};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin : main
        logic b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_val("R13 reset pin_o", pin_o, 4'h0);
        check_val("R13 reset pin_oe", pin_oe, 4'h0);

        // R1 R2 R3: literal selection, empty and contradictory terms, own groups
        blank_cfg();
        ctl[0] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b1);
        fz[0][0] = 16'h0009;
        ctl[1] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b1);
        ctl[2] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b1);
        fz[2][1] = 16'h0000;
        load_cfg();
        in_r = 4'b0001; #1;
        check_val("R1 in0 and not in1", {3'b0, pin_o[0]}, 4'h1);
        check_val("R1 empty term is 1", {3'b0, pin_o[2]}, 4'h1);
        check_val("R2 contradictory terms only", {3'b0, pin_o[1]}, 4'h0);
        check_val("R10 output mode drives", pin_oe, 4'b0111);
        in_r = 4'b0011; #1;
        check_val("R3 combinational follows inputs", {3'b0, pin_o[0]}, 4'h0);
        check_outputs("R3");

        // R4 polarity
        ctl[0] = mk_ctl(2'd1, 3'd0, 1'b1, 1'b1);
        load_cfg();
        in_r = 4'b0001; #1;
        check_val("R4 inverted polarity", {3'b0, pin_o[0]}, 4'h0);

        // R6 JK toggle with J=K=1
        blank_cfg();
        ctl[0] = mk_ctl(2'd1, 3'd1, 1'b0, 1'b0);
        fz[0][0] = 16'h0000;
        fz[0][2] = 16'h0000;
        load_cfg();
        #1; b0 = pin_o[0];
        step(1'b0, 1'b0, 1'b0); #1;
        check_val("R6 JK toggle", {3'b0, pin_o[0]}, {3'b0, !b0});
        step(1'b0, 1'b0, 1'b0); #1;
        check_val("R6 JK toggle back", {3'b0, pin_o[0]}, {3'b0, b0});

        // R7 set/reset: S=in0, R=in1
        ctl[0] = mk_ctl(2'd1, 3'd2, 1'b0, 1'b0);
        fz[0][0] = 16'h0001;
        fz[0][2] = 16'h0004;
        load_cfg();
        in_r = 4'b0001; step(1'b0, 1'b0, 1'b0); #1;
        check_val("R7 set", {3'b0, pin_o[0]}, 4'h1);
        in_r = 4'b0011; step(1'b0, 1'b0, 1'b0); #1;
        check_val("R7 both high holds 1", {3'b0, pin_o[0]}, 4'h1);
        in_r = 4'b0010; step(1'b0, 1'b0, 1'b0); #1;
        check_val("R7 reset", {3'b0, pin_o[0]}, 4'h0);
        in_r = 4'b0011; step(1'b0, 1'b0, 1'b0); #1;
        check_val("R7 both high holds 0", {3'b0, pin_o[0]}, 4'h0);

        // R8 transparent latch: data=in0, gate=in1
        ctl[0] = mk_ctl(2'd1, 3'd4, 1'b0, 1'b0);
        load_cfg();
        in_r = 4'b0011; step(1'b0, 1'b0, 1'b0);
        in_r = 4'b0000; #1;
        check_val("R8 closed gate keeps 1", {3'b0, pin_o[0]}, 4'h1);
        in_r = 4'b0010; #1;
        check_val("R8 open gate passes 0 without clock", {3'b0, pin_o[0]}, 4'h0);
        in_r = 4'b0011; #1;
        check_val("R8 open gate passes 1", {3'b0, pin_o[0]}, 4'h1);

        // R5 toggle and D
        ctl[0] = mk_ctl(2'd1, 3'd3, 1'b0, 1'b0);
        fz[0][0] = 16'h0000;
        load_cfg();
        #1; b0 = pin_o[0];
        step(1'b0, 1'b0, 1'b0); #1;
        check_val("R5 T toggles", {3'b0, pin_o[0]}, {3'b0, !b0});
        ctl[0] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b0);
        fz[0][0] = 16'h0001;
        fz[0][2] = 16'h0003;
        load_cfg();
        in_r = 4'b0001; step(1'b0, 1'b0, 1'b0); in_r = 4'b0000; #1;
        check_val("R5 D captures 1", {3'b0, pin_o[0]}, 4'h1);
        step(1'b0, 1'b0, 1'b0); #1;
        check_val("R5 D captures 0", {3'b0, pin_o[0]}, 4'h0);

        // R9 feedback: registered state, and pad value when combinational
        blank_cfg();
        ctl[0] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b0);
        fz[0][0] = 16'h0200;
        ctl[1] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b1);
        fz[1][0] = 16'h0400;
        load_cfg();
        #1; b0 = pin_o[0];
        step(1'b0, 1'b0, 1'b0); #1;
        check_val("R9 registered feedback toggles", {3'b0, pin_o[0]}, {3'b0, !b0});
        pin_r = 4'b0010; #1;
        check_val("R9 pad feedback high", {3'b0, pin_o[1]}, 4'h1);
        pin_r = 4'b0000; #1;
        check_val("R9 pad feedback low", {3'b0, pin_o[1]}, 4'h0);

        // R10 bidirectional: term3=in3 is enable only
        blank_cfg();
        ctl[0] = mk_ctl(2'd2, 3'd0, 1'b0, 1'b1);
        fz[0][3] = 16'h0040;
        load_cfg();
        in_r = 4'b1000; #1;
        check_val("R10 bidir enable on", pin_oe, 4'b0001);
        check_val("R2 term3 excluded from sum", {3'b0, pin_o[0]}, 4'h0);
        in_r = 4'b0000; #1;
        check_val("R10 bidir enable off", pin_oe, 4'b0000);

        // R11 shifted word has no effect until commit
        ctl[0] = mk_ctl(2'd1, 3'd0, 1'b0, 1'b1);
        fz[0][0] = 16'h0000;
        shift_cfg();
        in_r = 4'b0000; #1;
        check_val("R11 old config before commit", pin_oe, 4'b0000);
        check_outputs("R11");
        step(1'b0, 1'b0, 1'b1); #1;
        check_val("R11 new config after commit", pin_oe, 4'b0001);
        check_val("R11 new value after commit", {3'b0, pin_o[0]}, 4'h1);

        // Random configurations against the bench model
        for (int trial = 0; trial < 16; trial++) begin
            for (int m = 0; m < NM; m++) begin
                for (int t = 0; t < 4; t++)
                    for (int b = 0; b < 16; b++) fz[m][t][b] = ($urandom % 6) == 0;
                ctl[m] = mk_ctl(2'($urandom % 3), 3'($urandom % 5),
                                1'($urandom % 2), 1'($urandom % 2));
            end
            load_cfg();
            for (int c = 0; c < 24; c++) begin
                in_r  = 4'($urandom);
                pin_r = 4'($urandom);
                #1;
                check_outputs("R2 random array");
                step(1'b0, 1'b0, 1'b0);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule